// File: doc/BRIEF.md
# Dual-Factor PWM Backlight Dimmer

This block drives a backlight enable line with a pulse-width modulated signal. The on time of each period is the product of two factors. One is a 12-bit brightness value that software writes through a small register port. The other is a 16-bit duty fraction, delivered once per frame by a content-analysis stage through a data input and a one-cycle valid strobe. The period length is a 24-bit register counted in clock cycles. The block works out the on time and applies it only when the running period wraps. Because of this, every pulse on the output belongs entirely to one setting.

A mode bit selects between normal dimming and a forced-off state. In the forced-off state the output is held low. A read of the brightness address then returns a fixed value, and the stored brightness is left untouched. The host writes the three registers and reads them back one cycle after the read strobe. The frame-analysis stage only pulses its valid strobe.

Top module: `bl_dimmer`

## Requirements
- R1: After reset the brightness register reads 0, the mode bit reads 1, the period register reads 1000, the content duty is 65535 (100%) and `pwm_o` stays low for at least the first 1000 cycles.
- R2: The brightness register sits at address 0x51 and takes `wdata_i[11:0]`. A read with `rd_en_i` high in one cycle presents its data on `rdata_o` in the next cycle, zero-extended.
- R3: Within every period of P cycles, `pwm_o` is high for exactly floor(B·C·P / (4095·65535)) cycles, where B is the brightness and C is the latest content duty captured while `cdu_vld_i` is high. C is an unsigned fraction in which 65535 means 100%.
- R4: The period register sits at address 0x54 and takes `wdata_i[23:0]`. A stored period of P ≥ 1 gives a period of P cycles. A stored 0 acts as a period of 1 and still reads back as 0.
- R5: A new brightness, content duty or period takes effect only at the start of the next period. The pulse in progress keeps the width it started with.
- R6: A brightness of 0 or a content duty of 0 gives a constant low output. B = 4095 together with C = 65535 gives a constant high output.
- R7: The mode bit is `wdata_i[0]` at address 0x53. While it is 0, `pwm_o` is low in every cycle after the write.
- R8: While the mode bit is 0, a read of 0x51 returns 1084. Once the mode bit is set back to 1, the earlier written brightness is returned again.
- R9: Writes to any address other than 0x51, 0x53 and 0x54 change no register. Reads of those other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 24 | Register write data |
| rdata_o | output | 24 | Read data, valid the cycle after `rd_en_i` |
| cdu_i | input | 16 | Content duty fraction, 65535 = 100% |
| cdu_vld_i | input | 1 | Captures `cdu_i` for the next period |
| pwm_o | output | 1 | Backlight PWM output, active high |

## Verification
The assertions assume that the write and read strobes are single-cycle pulses. They also assume that `addr_i` and `wdata_i` are stable while a strobe is high. The content strobe is taken to arrive on its own, not in every cycle. The stimulus drives every input on the falling clock edge and raises each strobe for exactly one cycle. Before it measures on-time, it waits for the old period and then the new period to pass after each configuration change. It measures on-time only over windows that are exactly one period long, so the measured high count does not depend on where the window starts.

// File: rtl/bl_pkg.sv
package bl_pkg;
   localparam int ADDR_W = 8;
   typedef logic [ADDR_W-1:0] bl_addr_t;

   // Register addresses seen by the host
   localparam bl_addr_t ADDR_BRIGHT = 8'h51;
   localparam bl_addr_t ADDR_MODE   = 8'h53;
   localparam bl_addr_t ADDR_PERIOD = 8'h54;

   // Brightness value returned while the output is forced off
   localparam int FORCED_BRIGHT_RD = 1084;
endpackage

// File: rtl/bl_regs.sv
module bl_regs
   import bl_pkg::*;
#(
   parameter int BRIGHT_W = 12,
   parameter int PER_W    = 24,
   parameter int DATA_W   = 24,
   parameter int PER_RST  = 1000
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic                rd_en_i,
   input  bl_addr_t            addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   output logic [BRIGHT_W-1:0] bright_o,
   output logic [PER_W-1:0]    per_o,
   output logic                mode_o
);
   localparam logic [DATA_W-1:0] FIXED_RD = DATA_W'(FORCED_BRIGHT_RD);

   logic [BRIGHT_W-1:0] bright_q;
   logic [PER_W-1:0]    per_q;
   logic                mode_q;
   logic [DATA_W-1:0]   rdata_q;
   logic                mapped;

   assign mapped = (addr_i == ADDR_BRIGHT) || (addr_i == ADDR_MODE) ||
                   (addr_i == ADDR_PERIOD);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bright_q <= '0;
         per_q    <= PER_W'(PER_RST);
         mode_q   <= 1'b1;
      end else if (wr_en_i) begin
         unique case (addr_i)
            ADDR_BRIGHT: bright_q <= wdata_i[BRIGHT_W-1:0];
            ADDR_MODE:   mode_q   <= wdata_i[0];
            ADDR_PERIOD: per_q    <= wdata_i[PER_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q <= '0;
      end else if (rd_en_i) begin
         unique case (addr_i)
            ADDR_BRIGHT: rdata_q <= mode_q ? DATA_W'(bright_q) : FIXED_RD;
            ADDR_MODE:   rdata_q <= DATA_W'(mode_q);
            ADDR_PERIOD: rdata_q <= DATA_W'(per_q);
            default:     rdata_q <= '0;
         endcase
      end
   end

   assign rdata_o  = rdata_q;
   assign bright_o = bright_q;
   assign per_o    = per_q;
   assign mode_o   = mode_q;

   // R9
   ign_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !mapped) |=> ($stable(bright_q) && $stable(mode_q) && $stable(per_q)));

   // R8
   fixed_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == ADDR_BRIGHT && !mode_q) |=> (rdata_o == FIXED_RD));

   // R2
   rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/bl_duty_calc.sv
module bl_duty_calc #(
   parameter int BRIGHT_W = 12,
   parameter int DUTY_W   = 16,
   parameter int PER_W    = 24,
   parameter int PER_RST  = 1000
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [BRIGHT_W-1:0] bright_i,
   input  logic [PER_W-1:0]    per_i,
   input  logic [DUTY_W-1:0]   cdu_i,
   input  logic                cdu_vld_i,
   output logic [PER_W-1:0]    hi_o,
   output logic [PER_W-1:0]    per_o
);
   localparam int PROD_W = BRIGHT_W + DUTY_W + PER_W;
   localparam logic [PROD_W-1:0] MAX_B = {{(PROD_W-BRIGHT_W){1'b0}}, {BRIGHT_W{1'b1}}};
   localparam logic [PROD_W-1:0] MAX_C = {{(PROD_W-DUTY_W){1'b0}}, {DUTY_W{1'b1}}};
   localparam logic [PROD_W-1:0] DEN   = MAX_B * MAX_C;

   logic [DUTY_W-1:0] cdu_q;
   logic [PER_W-1:0]  eff_per;
   logic [PROD_W-1:0] prod;
   logic [PER_W-1:0]  hi_q;
   logic [PER_W-1:0]  per_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cdu_q <= '1;
      else if (cdu_vld_i) cdu_q <= cdu_i;
   end

   assign eff_per = (per_i == '0) ? PER_W'(1) : per_i;
   assign prod    = PROD_W'(bright_i) * PROD_W'(cdu_q) * PROD_W'(eff_per);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_q  <= '0;
         per_q <= PER_W'(PER_RST);
      end else begin
         hi_q  <= PER_W'(prod / DEN);
         per_q <= eff_per;
      end
   end

   assign hi_o  = hi_q;
   assign per_o = per_q;

   // R6
   zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bright_i == '0 || cdu_q == '0) |=> (hi_q == '0));

   // R6
   full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bright_i == '1 && cdu_q == '1) |=> (hi_q == per_q));
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
   parameter int PER_W   = 24,
   parameter int PER_RST = 1000,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [PER_W-1:0] hi_i,
   input  logic [PER_W-1:0] per_i,
   output logic             pwm_o
);
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] hi_q;
   logic             wrap;
   logic             pwm_raw;

   assign wrap = (cnt_q == per_q - PER_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         per_q <= PER_W'(PER_RST);
         hi_q  <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
         per_q <= per_i;
         hi_q  <= hi_i;
      end else begin
         cnt_q <= cnt_q + PER_W'(1);
      end
   end

   assign pwm_raw = en_i && (cnt_q < hi_q);

   if (REG_OUT) begin : g_reg_out
      logic pwm_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) pwm_q <= 1'b0;
         else         pwm_q <= pwm_raw;
      end
      assign pwm_o = pwm_q;
   end else begin : g_comb_out
      assign pwm_o = pwm_raw;
   end

   // R5
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap |=> ($stable(hi_q) && $stable(per_q)));

   // R4
   cnt_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q < per_q) && (per_q != '0));

   // R3
   hi_le_per_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_q <= per_q);
endmodule

// File: rtl/bl_dimmer.sv
module bl_dimmer
   import bl_pkg::*;
#(
   parameter int BRIGHT_W = 12,
   parameter int DUTY_W   = 16,
   parameter int PER_W    = 24,
   parameter int DATA_W   = 24,
   parameter int PER_RST  = 1000,
   parameter bit REG_OUT  = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [DUTY_W-1:0] cdu_i,
   input  logic              cdu_vld_i,
   output logic              pwm_o
);
   if (BRIGHT_W < 1 || DUTY_W < 1 || PER_W < 2) begin : g_bad_width
      $error("bl_dimmer: field widths too small");
   end
   if (DATA_W < PER_W || DATA_W < BRIGHT_W) begin : g_bad_data
      $error("bl_dimmer: DATA_W must hold every register");
   end
   if (PER_RST < 1) begin : g_bad_rst
      $error("bl_dimmer: reset period must be at least 1");
   end

   logic [BRIGHT_W-1:0] bright;
   logic [PER_W-1:0]    per_reg;
   logic                mode;
   logic [PER_W-1:0]    hi_calc;
   logic [PER_W-1:0]    per_calc;

   bl_regs #(
      .BRIGHT_W(BRIGHT_W), .PER_W(PER_W), .DATA_W(DATA_W), .PER_RST(PER_RST)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .bright_o(bright), .per_o(per_reg), .mode_o(mode)
   );

   bl_duty_calc #(
      .BRIGHT_W(BRIGHT_W), .DUTY_W(DUTY_W), .PER_W(PER_W), .PER_RST(PER_RST)
   ) u_calc (
      .clk_i(clk_i), .rst_ni(rst_ni), .bright_i(bright), .per_i(per_reg),
      .cdu_i(cdu_i), .cdu_vld_i(cdu_vld_i), .hi_o(hi_calc), .per_o(per_calc)
   );

   bl_pwm_core #(
      .PER_W(PER_W), .PER_RST(PER_RST), .REG_OUT(REG_OUT)
   ) u_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mode), .hi_i(hi_calc),
      .per_i(per_calc), .pwm_o(pwm_o)
   );

   // R7
   mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode && !$past(mode)) |-> !pwm_o);
endmodule

// File: tb/sim_bl_dimmer.sv
module sim_bl_dimmer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [23:0] wdata = '0;
   logic [23:0] rdata;
   logic [15:0] cdu = '0;
   logic        cdu_vld = 1'b0;
   logic        pwm;

   int compared = 0;
   int mismatched = 0;
   longint cur_p = 1000;

   always #5 clk = ~clk;

   bl_dimmer u0 (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cdu_i(cdu),
      .cdu_vld_i(cdu_vld), .pwm_o(pwm)
   );

   function automatic longint exp_hi(longint b, longint c, longint p);
      longint pe = (p == 0) ? 1 : p;
      return (b * c * pe) / (64'd4095 * 64'd65535);
   endfunction

   task automatic chk(string req, longint act, longint exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic reg_wr(logic [7:0] a, logic [23:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(logic [7:0] a, output logic [23:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic count_high(longint n, output longint hi);
      hi = 0;
      for (longint i = 0; i < n; i++) begin
         if (pwm) hi++;
         @(negedge clk);
      end
   endtask

   task automatic configure(longint p, longint b, longint c);
      longint old_p = (cur_p == 0) ? 1 : cur_p;
      longint new_p = (p == 0) ? 1 : p;
      reg_wr(8'h54, 24'(p));
      reg_wr(8'h51, 24'(b));
      cdu = 16'(c); cdu_vld = 1'b1;
      @(negedge clk);
      cdu_vld = 1'b0;
      cur_p = p;
      repeat (int'(old_p + new_p + 5)) @(negedge clk);
   endtask

   task automatic wait_rise();
      logic prev = pwm;
      @(negedge clk);
      while (!(pwm && !prev)) begin
         prev = pwm;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [23:0] d;
      longint hi;
      count_high(990, hi);
      chk("R1 pwm low after reset", hi, 0);
      reg_rd(8'h51, d); chk("R1 brightness reset", d, 0);
      reg_rd(8'h53, d); chk("R1 mode reset", d, 1);
      reg_rd(8'h54, d); chk("R1 period reset", d, 1000);
   endtask

   task automatic t_duty(longint p, longint b, longint c);
      longint hi;
      logic [23:0] d;
      configure(p, b, c);
      reg_rd(8'h51, d); chk("R2 brightness readback", d, b);
      count_high(p, hi);
      chk("R3 high cycles per period", hi, exp_hi(b, c, p));
   endtask

   task automatic t_extremes();
      longint hi;
      configure(200, 0, 65535);
      count_high(200, hi); chk("R6 zero brightness", hi, 0);
      configure(200, 4095, 0);
      count_high(200, hi); chk("R6 zero content duty", hi, 0);
      configure(200, 4095, 65535);
      count_high(200, hi); chk("R6 full scale", hi, 200);
   endtask

   task automatic t_period_zero();
      longint hi;
      logic [23:0] d;
      configure(0, 4095, 65535);
      count_high(20, hi); chk("R4 period zero acts as one", hi, 20);
      reg_rd(8'h54, d); chk("R4 period zero readback", d, 0);
   endtask

   task automatic t_glitch();
      longint n;
      configure(400, 4095, 32768);
      wait_rise();
      n = 1;
      while (pwm) begin
         wr_en = (n == 20); addr = 8'h51; wdata = 24'd1024;
         @(negedge clk);
         wr_en = 1'b0;
         if (pwm) n++;
      end
      chk("R5 pulse in progress keeps width", n, exp_hi(4095, 32768, 400));
      wait_rise();
      n = 1;
      @(negedge clk);
      while (pwm) begin n++; @(negedge clk); end
      chk("R5 next pulse uses new value", n, exp_hi(1024, 32768, 400));
   endtask

   task automatic t_mode();
      longint hi;
      logic [23:0] d;
      reg_wr(8'h53, 24'd0);
      count_high(400, hi); chk("R7 forced low", hi, 0);
      reg_rd(8'h51, d); chk("R8 fixed readback", d, 1084);
      reg_rd(8'h53, d); chk("R7 mode readback", d, 0);
      reg_wr(8'h53, 24'd1);
      reg_rd(8'h51, d); chk("R8 stored value restored", d, 1024);
      repeat (805) @(negedge clk);
      count_high(400, hi); chk("R8 dimming resumes", hi, exp_hi(1024, 32768, 400));
   endtask

   task automatic t_ignored();
      longint hi;
      logic [23:0] d;
      reg_wr(8'h50, 24'hFFFFFF);
      reg_wr(8'h52, 24'hFFFFFF);
      reg_wr(8'h55, 24'h000000);
      reg_rd(8'h51, d); chk("R9 brightness untouched", d, 1024);
      reg_rd(8'h53, d); chk("R9 mode untouched", d, 1);
      reg_rd(8'h54, d); chk("R9 period untouched", d, 400);
      reg_rd(8'h50, d); chk("R9 unmapped reads zero", d, 0);
      count_high(400, hi); chk("R9 output unchanged", hi, exp_hi(1024, 32768, 400));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_duty(2950, 2048, 48771);
      t_duty(200, 4095, 32768);
      t_duty(500, 1000, 65535);
      t_duty(777, 3000, 12345);
      t_extremes();
      t_period_zero();
      t_glitch();
      t_mode();
      t_ignored();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule